// File: doc/BRIEF.md
# Packed 8-bit SIMD add/subtract unit

This execution unit treats two register-width operands as a row of independent 8-bit lanes and applies one of ten lane-wise arithmetic operations to all lanes at once. Three families of operation are offered: wrapping add and subtract, halving add and subtract (signed or unsigned), and saturating add and subtract (signed or unsigned). The operand width is a parameter (32 or 64 bits), and the number of lanes is that width divided by eight.

The unit receives the raw 32-bit instruction word together with both source values. It decodes the word and registers its outputs, so every result appears one clock after the instruction is presented. The outputs are the destination value, a result-valid strobe and an illegal-instruction strobe. When any lane of a saturating operation clamps, the unit raises a one-cycle pulse and sets a sticky flag, which stays set until the clear input is driven.

The wrapping forms share one full-width adder. The sign bit of every lane is masked off before the add, so no carry or borrow crosses a lane boundary, and the true lane sign bits are then restored with an XOR. The halving and saturating forms use a small widened adder in each lane.

Top module: `psimd8_unit`

## Requirements
- R1: An instruction is legal only when bits[6:0] = 7'b1111111, bits[14:12] = 3'b000 and funct7 bits[31:25] is one of the ten operation codes listed in R2 to R7. Any other word presented with insn_valid gives res_illegal = 1.
- R2: funct7 7'b0100100 (wrapping add) gives, in each lane, (a + b) mod 256, with no carry into the neighbouring lane.
- R3: funct7 7'b0100101 (wrapping subtract) gives, in each lane, (a - b) mod 256, with no borrow from the neighbouring lane.
- R4: funct7 7'b0000100 and 7'b0000101 (signed halving add and subtract) give, per lane, bits [8:1] of the exact sum or difference of the sign-extended lanes. This is an arithmetic shift right by one.
- R5: funct7 7'b0010100 and 7'b0010101 (unsigned halving add and subtract) give, per lane, bits [8:1] of the exact sum or difference of the zero-extended lanes.
- R6: funct7 7'b0001100 and 7'b0001101 (signed saturating add and subtract) clamp each lane result to the range [-128, 127].
- R7: funct7 7'b0011100 and 7'b0011101 (unsigned saturating add and subtract) clamp each lane result to the range [0, 255]. A subtract that would go below zero returns 0.
- R8: sat_pulse is high for one cycle, in the same cycle as the result, when any lane of a legal saturating operation clamps. sat_sticky becomes 1 with that pulse and stays 1 until sat_clear is sampled. A pulse in the cycle after sat_clear sets the flag again, because setting takes priority over clearing.
- R9: An illegal instruction gives res_data = 0 and no sat_pulse.
- R10: The outputs res_valid, res_illegal, res_data and sat_pulse are registered. They reflect the inputs sampled on the previous rising edge. With insn_valid low, all four are 0.
- R11: A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | Raw instruction word |
| src_a | input | XLEN | First packed operand |
| src_b | input | XLEN | Second packed operand |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| res_valid | output | 1 | A result (legal or not) is presented |
| res_illegal | output | 1 | The presented instruction was not recognised |
| res_data | output | XLEN | Packed destination value |
| sat_pulse | output | 1 | One lane or more clamped in this result |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The outputs are registered once, so a fault in decode, in a lane or in the mask adder shows on res_data in the very next cycle, in the lane it affected. Any single lane whose sign bit is masked wrongly, or whose clamp condition misses an edge, shows as a wrong byte for a few specific operand pairs only. For that reason, every one of the 65,536 lane operand pairs is driven through every operation. A wrong sticky-flag state shows on sat_sticky one cycle after the event that should have set or cleared it. The model tracks the flag across the whole sweep.

// File: rtl/psimd8_pkg.sv
package psimd8_pkg;

    localparam int LANE_W   = 8;
    localparam int EXT_W    = LANE_W + 2;
    localparam logic [6:0] MAJOR_OP = 7'b1111111;
    localparam logic [2:0] GROUP_F3 = 3'b000;

    typedef enum logic [3:0] {
        OP_WADD, OP_WSUB,
        OP_HADD_S, OP_HADD_U, OP_HSUB_S, OP_HSUB_U,
        OP_SADD_S, OP_SADD_U, OP_SSUB_S, OP_SSUB_U,
        OP_NONE
    } op_e;

    typedef struct packed {
        logic sub;    // subtract instead of add
        logic sgn;    // sign-extend lanes
        logic halve;  // return bits [8:1]
        logic sat;    // clamp to lane range
        logic wrap;   // use the shared masked adder
    } lane_ctl_t;

    function automatic op_e op_of_f7(input logic [6:0] f7);
        case (f7)
            7'b0100100: return OP_WADD;
            7'b0100101: return OP_WSUB;
            7'b0000100: return OP_HADD_S;
            7'b0000101: return OP_HSUB_S;
            7'b0010100: return OP_HADD_U;
            7'b0010101: return OP_HSUB_U;
            7'b0001100: return OP_SADD_S;
            7'b0001101: return OP_SSUB_S;
            7'b0011100: return OP_SADD_U;
            7'b0011101: return OP_SSUB_U;
            default:    return OP_NONE;
        endcase
    endfunction

    function automatic lane_ctl_t ctl_of(input op_e op);
        lane_ctl_t c;
        c = '0;
        case (op)
            OP_WADD:   c.wrap = 1'b1;
            OP_WSUB:   begin c.wrap = 1'b1; c.sub = 1'b1; end
            OP_HADD_S: begin c.halve = 1'b1; c.sgn = 1'b1; end
            OP_HADD_U: c.halve = 1'b1;
            OP_HSUB_S: begin c.halve = 1'b1; c.sgn = 1'b1; c.sub = 1'b1; end
            OP_HSUB_U: begin c.halve = 1'b1; c.sub = 1'b1; end
            OP_SADD_S: begin c.sat = 1'b1; c.sgn = 1'b1; end
            OP_SADD_U: c.sat = 1'b1;
            OP_SSUB_S: begin c.sat = 1'b1; c.sgn = 1'b1; c.sub = 1'b1; end
            OP_SSUB_U: begin c.sat = 1'b1; c.sub = 1'b1; end
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/psimd8_decode.sv
module psimd8_decode
    import psimd8_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output op_e        op,
    output logic       legal
);
    always_comb begin
        op    = op_of_f7(funct7);
        legal = (opcode == MAJOR_OP) && (funct3 == GROUP_F3) && (op != OP_NONE);
    end
endmodule

// File: rtl/psimd8_wrap.sv
module psimd8_wrap
    import psimd8_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] y
);
    localparam int LANES = XLEN / LANE_W;
    localparam logic [LANE_W-1:0] TOP_BIT = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [XLEN-1:0] SIGN_MASK = {LANES{TOP_BIT}};

    logic [XLEN-1:0] low_sum, low_diff;

    always_comb begin
        // sign bits are kept out of the carry chain, then restored by XOR
        low_sum  = (a & ~SIGN_MASK) + (b & ~SIGN_MASK);
        low_diff = (a | SIGN_MASK) - (b & ~SIGN_MASK);
        if (sub)
            y = low_diff ^ (~(a ^ b) & SIGN_MASK);
        else
            y = low_sum ^ ((a ^ b) & SIGN_MASK);
    end
endmodule

// File: rtl/psimd8_lane.sv
module psimd8_lane
    import psimd8_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  lane_ctl_t         ctl,
    output logic [LANE_W-1:0] y,
    output logic [LANE_W-1:0] raw,
    output logic              clamp
);
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [EXT_W-1:0] ea, eb, s;
    logic             hi, lo;

    always_comb begin
        ea = ctl.sgn ? {{2{a[LANE_W-1]}}, a} : {2'b00, a};
        eb = ctl.sgn ? {{2{b[LANE_W-1]}}, b} : {2'b00, b};
        s  = ctl.sub ? ea - eb : ea + eb;
        raw = s[LANE_W-1:0];
        if (ctl.sgn) begin
            hi = !s[EXT_W-1] && (s[EXT_W-2:LANE_W-1] != 2'b00);
            lo =  s[EXT_W-1] && (s[EXT_W-2:LANE_W-1] != 2'b11);
        end else begin
            hi = !ctl.sub && s[LANE_W];
            lo =  ctl.sub && s[EXT_W-1];
        end
        clamp = ctl.sat && (hi || lo);
        if (ctl.halve)
            y = s[LANE_W:1];
        else if (ctl.sat && hi)
            y = ctl.sgn ? S_MAX : '1;
        else if (ctl.sat && lo)
            y = ctl.sgn ? S_MIN : '0;
        else
            y = raw;
    end
endmodule

// File: rtl/psimd8_unit.sv
module psimd8_unit
    import psimd8_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            sat_clear,
    output logic            res_valid,
    output logic            res_illegal,
    output logic [XLEN-1:0] res_data,
    output logic            sat_pulse,
    output logic            sat_sticky
);
    localparam int LANES = XLEN / LANE_W;

    op_e             op;
    logic            legal;
    lane_ctl_t       ctl;
    logic [XLEN-1:0] wrap_y, lane_y, lane_raw;
    logic [LANES-1:0] lane_clamp;
    logic [XLEN-1:0] comb_y;
    logic            any_clamp;
    logic            unused_fields;

    assign unused_fields = ^{insn[24:15], insn[11:7]};

    psimd8_decode u_dec (
        .opcode (insn[6:0]),
        .funct3 (insn[14:12]),
        .funct7 (insn[31:25]),
        .op     (op),
        .legal  (legal)
    );

    assign ctl = ctl_of(op);

    psimd8_wrap #(.XLEN(XLEN)) u_wrap (
        .a   (src_a),
        .b   (src_b),
        .sub (ctl.sub),
        .y   (wrap_y)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psimd8_lane u_lane (
            .a     (src_a[g*LANE_W +: LANE_W]),
            .b     (src_b[g*LANE_W +: LANE_W]),
            .ctl   (ctl),
            .y     (lane_y[g*LANE_W +: LANE_W]),
            .raw   (lane_raw[g*LANE_W +: LANE_W]),
            .clamp (lane_clamp[g])
        );
    end

    assign comb_y    = ctl.wrap ? wrap_y : lane_y;
    assign any_clamp = |lane_clamp;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
            res_data    <= '0;
            sat_pulse   <= 1'b0;
            sat_sticky  <= 1'b0;
        end else begin
            res_valid   <= insn_valid;
            res_illegal <= insn_valid && !legal;
            res_data    <= (insn_valid && legal) ? comb_y : '0;
            sat_pulse   <= insn_valid && legal && any_clamp;
            if (insn_valid && legal && any_clamp)
                sat_sticky <= 1'b1;
            else if (sat_clear)
                sat_sticky <= 1'b0;
        end
    end

    // shared masked adder must agree with the unsigned lane adders
    p_wrap_agrees_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WADD || op == OP_WSUB) |-> (wrap_y == lane_raw));

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
        res_illegal |-> (res_data == '0 && !sat_pulse && res_valid));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> (!res_valid && !sat_pulse && res_data == '0));

    p_pulse_sets_r8: assert property (@(posedge clk) disable iff (rst)
        sat_pulse |-> sat_sticky);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        sat_clear |=> (sat_sticky == sat_pulse));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky && !sat_clear) |=> sat_sticky);

    p_clamp_only_sat_r6: assert property (@(posedge clk) disable iff (rst)
        !ctl.sat |-> (lane_clamp == '0));
endmodule

// File: tb/sim_psimd8_unit.sv
module sim_psimd8_unit;
    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            insn_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic [XLEN-1:0] src_a = '0, src_b = '0;
    logic            sat_clear = 1'b0;
    logic            res_valid, res_illegal, res_pulse_unused;
    logic [XLEN-1:0] res_data;
    logic            sat_pulse, sat_sticky;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit exp_sticky = 0;

    always #5 clk = ~clk;

    psimd8_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
        .src_a(src_a), .src_b(src_b), .sat_clear(sat_clear),
        .res_valid(res_valid), .res_illegal(res_illegal), .res_data(res_data),
        .sat_pulse(sat_pulse), .sat_sticky(sat_sticky)
    );
    assign res_pulse_unused = 1'b0;

    function automatic logic [6:0] f7_of(input int idx);
        case (idx)
            0: return 7'b0100100; 1: return 7'b0000100; 2: return 7'b0010100;
            3: return 7'b0001100; 4: return 7'b0011100; 5: return 7'b0100101;
            6: return 7'b0000101; 7: return 7'b0010101; 8: return 7'b0001101;
            default: return 7'b0011101;
        endcase
    endfunction

    function automatic logic [31:0] mk_insn(input logic [6:0] f7, input logic [2:0] f3,
                                            input logic [6:0] opc);
        return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
    endfunction

    function automatic string req_of(input int idx);
        case (idx % 5)
            0: return (idx >= 5) ? "R3" : "R2";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic int lane_ref(input int idx, input int a, input int b, output bit clamp);
        bit sub;
        int sa, sb, r;
        sub = (idx >= 5);
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        clamp = 0;
        case (idx % 5)
            0: r = sub ? a - b : a + b;
            1: r = (sub ? sa - sb : sa + sb) >>> 1;
            2: r = (sub ? a - b : a + b) >>> 1;
            3: begin
                r = sub ? sa - sb : sa + sb;
                if (r > 127) begin r = 127; clamp = 1; end
                else if (r < -128) begin r = -128; clamp = 1; end
            end
            default: begin
                r = sub ? a - b : a + b;
                if (r > 255) begin r = 255; clamp = 1; end
                else if (r < 0) begin r = 0; clamp = 1; end
            end
        endcase
        return r & 255;
    endfunction

    function automatic logic [XLEN-1:0] word_ref(input int idx, input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b, output bit any);
        logic [XLEN-1:0] w;
        bit c;
        any = 0;
        for (int k = 0; k < LANES; k++) begin
            w[k*8 +: 8] = 8'(lane_ref(idx, int'(a[k*8 +: 8]), int'(b[k*8 +: 8]), c));
            any = any | c;
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // present one cycle of inputs at a falling edge; outputs are read at the next one
    task automatic step(input bit vld, input logic [31:0] w, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b, input bit clr);
        insn_valid = vld; insn = w; src_a = a; src_b = b; sat_clear = clr;
        @(negedge clk);
    endtask

    task automatic run_op(input int idx, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        logic [XLEN-1:0] e;
        bit any;
        e = word_ref(idx, a, b, any);
        step(1'b1, mk_insn(f7_of(idx), 3'b000, 7'b1111111), a, b, 1'b0);
        if (any) exp_sticky = 1;
        check(res_data == e && res_valid && !res_illegal, req_of(idx), "data",
              64'(res_data), 64'(e));
        check(sat_pulse == any, any ? "R8" : req_of(idx), "pulse",
              64'(sat_pulse), 64'(any));
        check(sat_sticky == exp_sticky, "R8", "sticky", 64'(sat_sticky), 64'(exp_sticky));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R11: reset state
        check(!res_valid && !res_illegal && res_data == '0 && !sat_pulse && !sat_sticky,
              "R11", "reset", {59'd0, res_valid, res_illegal, sat_pulse, sat_sticky, |res_data}, 64'd0);
        rst = 1'b0;

        // R10: idle cycle keeps outputs low
        step(1'b0, mk_insn(f7_of(3), 3'b000, 7'b1111111), 32'h7F7F7F7F, 32'h01010101, 1'b0);
        check(!res_valid && !sat_pulse && res_data == '0, "R10", "idle",
              64'(res_data), 64'd0);

        // boundary operands in every variant: lanes 7F+01, 80-01 style, FF/FF, 00/FF
        for (int idx = 0; idx < 10; idx++)
            run_op(idx, 32'h00FF807F, 32'hFFFF0101);

        // R1 / R9: unknown funct7, wrong major opcode, wrong funct3
        step(1'b1, mk_insn(7'b1111111, 3'b000, 7'b1111111), 32'h7F7F7F7F, 32'h01010101, 1'b0);
        check(res_illegal && res_valid && res_data == '0 && !sat_pulse, "R1", "bad funct7",
              64'(res_data), 64'd0);
        step(1'b1, mk_insn(f7_of(3), 3'b000, 7'b0110011), 32'h7F7F7F7F, 32'h01010101, 1'b0);
        check(res_illegal && res_data == '0 && !sat_pulse, "R9", "bad opcode",
              64'(res_data), 64'd0);
        step(1'b1, mk_insn(f7_of(4), 3'b010, 7'b1111111), 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
        check(res_illegal && res_data == '0 && !sat_pulse, "R1", "bad funct3",
              64'(res_data), 64'd0);

        // R8: clear, then clear and a new clamp together (set wins)
        step(1'b0, '0, '0, '0, 1'b1);
        exp_sticky = 0;
        check(!sat_sticky, "R8", "cleared", 64'(sat_sticky), 64'd0);
        step(1'b1, mk_insn(f7_of(4), 3'b000, 7'b1111111), 32'h000000FF, 32'h00000001, 1'b1);
        exp_sticky = 1;
        check(sat_pulse && sat_sticky, "R8", "set beats clear",
              {62'd0, sat_pulse, sat_sticky}, 64'd3);
        step(1'b1, mk_insn(f7_of(4), 3'b000, 7'b1111111), 32'h00000001, 32'h00000001, 1'b0);
        check(!sat_pulse && sat_sticky, "R8", "no clamp holds",
              {62'd0, sat_pulse, sat_sticky}, 64'd1);
        step(1'b0, '0, '0, '0, 1'b1);
        exp_sticky = 0;
        check(!sat_sticky && !sat_pulse, "R8", "clear again", 64'(sat_sticky), 64'd0);

        // exhaustive lane pairs, four pairs per instruction
        for (int idx = 0; idx < 10; idx++) begin
            for (int i = 0; i < 16384; i++) begin
                logic [XLEN-1:0] a, b;
                for (int k = 0; k < LANES; k++) begin
                    logic [15:0] p;
                    p = 16'(i * 4 + k);
                    a[k*8 +: 8] = p[15:8];
                    b[k*8 +: 8] = p[7:0];
                end
                run_op(idx, a, b);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule